// File: doc/BRIEF.md
# Looping Transmit Frame Sequencer

This block replays a stored payload without end and wraps every pass in a complete frame. The local buffer holds payload samples only. It is filled through a write port while playback is halted. Each pass starts with a short training field and then a channel estimation field, both read from constant pattern tables. The buffered payload follows, read from address 0. A programmable number of training subfields comes next, and a silent gap closes the pass before the next one begins.

During the training subfields the block steps a beam-configuration index, so that downstream antenna control sweeps one beam pattern per subfield. Every output sample carries a field code, and a strobe marks the first sample of each frame. All frame settings are captured when playback starts. Software can therefore prepare the next setup while the current one is running.

Top module: `frame_loop_seq`

## Requirements
- R1: During and directly after reset, `out_valid` is 0, `out_field` is 0, `out_sof` is 0, `out_beam` is 0 and the I/Q outputs are 0.
- R2: When `start` is high at a clock edge while stopped and `stop` is low, the outputs from the next cycle on are valid and show field code 1, the first short training sample and `out_sof`=1. A `start` while running has no effect.
- R3: Each pass is ordered as follows. Field code 1 lasts STF_LEN*(`cfg_stf_rep`+1) samples. Field code 2 lasts CEF_LEN*(`cfg_cef_rep`+1) samples. Field code 3 lasts `cfg_pay_last`+1 samples. Field code 4 lasts TRN_LEN*`cfg_trn_num` samples. Field code 5 lasts `cfg_gap` samples. The next pass follows with no break. Field code 0 means stopped.
- R4: The payload field outputs buffer words at addresses 0, 1, ... `cfg_pay_last` in that order, on every pass.
- R5: Let A = 2^(SW-2), and let k be the sample index within one repetition of a field. In the short training field, I = +A when k is even and -A otherwise, and Q = +A when bit 1 of k is 0 and -A otherwise. In the channel estimation field, I = -A when bit (k mod 16) of 16'h0F35 is 1 and +A otherwise, and Q = -I. In a training subfield, I = +A for k < TRN_LEN/2 and -A otherwise, and Q = 0.
- R6: `out_beam` equals the `cfg_beam` value captured at start in every sample outside the training fields. During training subfield j (counting from 0) it equals `cfg_beam`+1+j modulo 2^BW.
- R7: During the gap, I and Q are 0 and `out_valid` stays 1. A `cfg_trn_num` of 0 omits the training field, and a `cfg_gap` of 0 omits the gap, so the payload or training field is followed directly by the next short training field.
- R8: A buffer write is ignored while playback runs. A write while stopped is stored, and this includes a write in the same cycle as the starting `start`.
- R9: When `stop` is high at an edge, the outputs from the next cycle on show `out_valid`=0 and field code 0. `stop` wins over a `start` in the same cycle.
- R10: A change to the configuration inputs during playback has no effect until the next start.
- R11: `out_sof` is 1 only on the first short training sample of each pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin playback pulse |
| stop | input | 1 | Halt playback pulse |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | AW | Buffer write address |
| wr_i | input | SW | Payload I sample to store |
| wr_q | input | SW | Payload Q sample to store |
| cfg_stf_rep | input | RW | Short training repetitions minus one |
| cfg_cef_rep | input | RW | Channel estimation repetitions minus one |
| cfg_pay_last | input | AW | Last payload address |
| cfg_trn_num | input | RW | Number of training subfields |
| cfg_gap | input | GW | Idle gap length in samples |
| cfg_beam | input | BW | Default beam index |
| out_valid | output | 1 | Sample valid |
| out_sof | output | 1 | First sample of a frame |
| out_field | output | 3 | Field code of the current sample |
| out_i | output | SW | Output I sample |
| out_q | output | SW | Output Q sample |
| out_beam | output | BW | Beam-configuration index |

## Verification
Two functions can meet in a single cycle. The first is a buffer write arriving on the same edge as the start pulse. The second is a stop and a start arriving together. The bench drives the final payload write to address 0 together with `start`, then judges the first payload sample of the pass, which must carry the new word. It also pulses `stop` and `start` together while halted and expects the outputs to stay idle. A behavioural model holds the expected frame as queues and is compared on every cycle, including the wrap of the beam index past its top value.

// File: rtl/frame_loop_pkg.sv
package frame_loop_pkg;

   // Field code carried beside every output sample
   typedef enum logic [2:0] {
      FLD_OFF = 3'd0,
      FLD_STF = 3'd1,
      FLD_CEF = 3'd2,
      FLD_PAY = 3'd3,
      FLD_TRN = 3'd4,
      FLD_GAP = 3'd5
   } fld_e;

   // Pattern table variants
   localparam int PAT_STF = 0;
   localparam int PAT_CEF = 1;
   localparam int PAT_TRN = 2;

   // Sign sequence of the channel estimation pattern
   localparam logic [15:0] CEF_SIGNS = 16'h0F35;

endpackage

// File: rtl/frame_pat_rom.sv
module frame_pat_rom
   import frame_loop_pkg::*;
#(
   parameter int KIND = PAT_STF,
   parameter int LEN  = 16,
   parameter int SW   = 12,
   localparam int LW  = (LEN > 1) ? $clog2(LEN) : 1
) (
   input  logic [LW-1:0] idx,
   output logic [SW-1:0] pat_i,
   output logic [SW-1:0] pat_q
);

   localparam logic [SW-1:0] POS = SW'(2 ** (SW - 2));
   localparam logic [SW-1:0] NEG = SW'(-(2 ** (SW - 2)));

   logic [SW-1:0] tab_i [LEN];
   logic [SW-1:0] tab_q [LEN];

   for (genvar k = 0; k < LEN; k++) begin : g_ent
      if (KIND == PAT_STF) begin : g_stf
         assign tab_i[k] = (k % 2 == 0) ? POS : NEG;
         assign tab_q[k] = ((k / 2) % 2 == 0) ? POS : NEG;
      end else if (KIND == PAT_CEF) begin : g_cef
         assign tab_i[k] = CEF_SIGNS[k % 16] ? NEG : POS;
         assign tab_q[k] = CEF_SIGNS[k % 16] ? POS : NEG;
      end else begin : g_trn
         assign tab_i[k] = (k < LEN / 2) ? POS : NEG;
         assign tab_q[k] = '0;
      end
   end

   assign pat_i = tab_i[idx];
   assign pat_q = tab_q[idx];

endmodule

// File: rtl/frame_pay_buf.sv
module frame_pay_buf #(
   parameter int DEPTH = 32,
   parameter int SW    = 12,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [SW-1:0] wr_i,
   input  logic [SW-1:0] wr_q,
   input  logic [AW-1:0] rd_addr,
   output logic [SW-1:0] rd_i,
   output logic [SW-1:0] rd_q
);

   logic [2*SW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && !lock) begin
         mem[wr_addr] <= {wr_i, wr_q};
      end
   end

   assign {rd_i, rd_q} = mem[rd_addr];

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && $past(lock) && $stable(rd_addr)) |-> ($stable(rd_i) && $stable(rd_q))); // R8

endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
   import frame_loop_pkg::*;
#(
   parameter int STF_LEN = 16,
   parameter int CEF_LEN = 32,
   parameter int TRN_LEN = 8,
   parameter int AW      = 5,
   parameter int IW      = 5,
   parameter int RW      = 4,
   parameter int GW      = 8,
   parameter int BW      = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          stop,
   input  logic [RW-1:0] cfg_stf_rep,
   input  logic [RW-1:0] cfg_cef_rep,
   input  logic [AW-1:0] cfg_pay_last,
   input  logic [RW-1:0] cfg_trn_num,
   input  logic [GW-1:0] cfg_gap,
   input  logic [BW-1:0] cfg_beam,
   output fld_e          fld,
   output logic [IW-1:0] idx,
   output logic [AW-1:0] addr,
   output logic [BW-1:0] beam,
   output logic          frame_first
);

   localparam logic [IW-1:0] STF_END = IW'(STF_LEN - 1);
   localparam logic [IW-1:0] CEF_END = IW'(CEF_LEN - 1);
   localparam logic [IW-1:0] TRN_END = IW'(TRN_LEN - 1);

   logic [RW-1:0] rep;
   logic [GW-1:0] gcnt;
   logic [RW-1:0] c_stf, c_cef, c_trn;
   logic [AW-1:0] c_last;
   logic [GW-1:0] c_gap;
   logic [BW-1:0] c_beam;
   fld_e          after_pay, after_trn;

   // Fields with a zero count are skipped
   assign after_trn = (c_gap != '0) ? FLD_GAP : FLD_STF;
   assign after_pay = (c_trn != '0) ? FLD_TRN : after_trn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fld    <= FLD_OFF;
         idx    <= '0;
         addr   <= '0;
         rep    <= '0;
         gcnt   <= '0;
         c_stf  <= '0;
         c_cef  <= '0;
         c_trn  <= '0;
         c_last <= '0;
         c_gap  <= '0;
         c_beam <= '0;
      end else if (stop) begin
         fld <= FLD_OFF;
      end else begin
         unique case (fld)
            FLD_OFF: begin
               if (start) begin
                  c_stf  <= cfg_stf_rep;
                  c_cef  <= cfg_cef_rep;
                  c_trn  <= cfg_trn_num;
                  c_last <= cfg_pay_last;
                  c_gap  <= cfg_gap;
                  c_beam <= cfg_beam;
                  fld    <= FLD_STF;
                  idx    <= '0;
                  rep    <= '0;
                  addr   <= '0;
                  gcnt   <= '0;
               end
            end
            FLD_STF: begin
               if (idx == STF_END) begin
                  idx <= '0;
                  if (rep == c_stf) begin
                     rep <= '0;
                     fld <= FLD_CEF;
                  end else begin
                     rep <= rep + 1'b1;
                  end
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            FLD_CEF: begin
               if (idx == CEF_END) begin
                  idx <= '0;
                  if (rep == c_cef) begin
                     rep  <= '0;
                     addr <= '0;
                     fld  <= FLD_PAY;
                  end else begin
                     rep <= rep + 1'b1;
                  end
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            FLD_PAY: begin
               if (addr == c_last) begin
                  addr <= '0;
                  idx  <= '0;
                  rep  <= '0;
                  gcnt <= '0;
                  fld  <= after_pay;
               end else begin
                  addr <= addr + 1'b1;
               end
            end
            FLD_TRN: begin
               if (idx == TRN_END) begin
                  idx <= '0;
                  if (rep == c_trn - RW'(1)) begin
                     rep  <= '0;
                     gcnt <= '0;
                     fld  <= after_trn;
                  end else begin
                     rep <= rep + 1'b1;
                  end
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            FLD_GAP: begin
               if (gcnt == c_gap - GW'(1)) begin
                  gcnt <= '0;
                  idx  <= '0;
                  rep  <= '0;
                  fld  <= FLD_STF;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: fld <= FLD_OFF;
         endcase
      end
   end

   assign beam        = (fld == FLD_TRN) ? (c_beam + BW'(rep) + BW'(1)) : c_beam;
   assign frame_first = (fld == FLD_STF) && (idx == '0) && (rep == '0);

   AST_FIRST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (fld != FLD_OFF && $past(fld) == FLD_OFF) |-> (fld == FLD_STF && idx == '0 && rep == '0)); // R2

   AST_FIELD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (fld != $past(fld) && fld != FLD_OFF && $past(fld) != FLD_OFF) |->
         (($past(fld) == FLD_STF && fld == FLD_CEF) ||
          ($past(fld) == FLD_CEF && fld == FLD_PAY) ||
          ($past(fld) == FLD_PAY && (fld == FLD_TRN || fld == FLD_GAP || fld == FLD_STF)) ||
          ($past(fld) == FLD_TRN && (fld == FLD_GAP || fld == FLD_STF)) ||
          ($past(fld) == FLD_GAP && fld == FLD_STF))); // R3

   AST_PAY_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fld == FLD_PAY && $past(fld) == FLD_CEF) |-> (addr == '0)); // R4

   AST_PAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (fld == FLD_PAY) |-> (addr <= c_last)); // R3

   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop) |-> (fld == FLD_OFF)); // R9

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fld != FLD_OFF && $past(fld) != FLD_OFF) |->
         ($stable(c_last) && $stable(c_gap) && $stable(c_trn) && $stable(c_beam))); // R10

endmodule

// File: rtl/frame_loop_seq.sv
module frame_loop_seq
   import frame_loop_pkg::*;
#(
   parameter int SW      = 12,
   parameter int DEPTH   = 32,
   parameter int STF_LEN = 16,
   parameter int CEF_LEN = 32,
   parameter int TRN_LEN = 8,
   parameter int RW      = 4,
   parameter int GW      = 8,
   parameter int BW      = 4,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          stop,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [SW-1:0] wr_i,
   input  logic [SW-1:0] wr_q,
   input  logic [RW-1:0] cfg_stf_rep,
   input  logic [RW-1:0] cfg_cef_rep,
   input  logic [AW-1:0] cfg_pay_last,
   input  logic [RW-1:0] cfg_trn_num,
   input  logic [GW-1:0] cfg_gap,
   input  logic [BW-1:0] cfg_beam,
   output logic          out_valid,
   output logic          out_sof,
   output logic [2:0]    out_field,
   output logic [SW-1:0] out_i,
   output logic [SW-1:0] out_q,
   output logic [BW-1:0] out_beam
);

   localparam int MAXL    = (STF_LEN > CEF_LEN) ? ((STF_LEN > TRN_LEN) ? STF_LEN : TRN_LEN)
                                                : ((CEF_LEN > TRN_LEN) ? CEF_LEN : TRN_LEN);
   localparam int IW      = $clog2(MAXL);
   localparam int STF_IW  = $clog2(STF_LEN);
   localparam int CEF_IW  = $clog2(CEF_LEN);
   localparam int TRN_IW  = $clog2(TRN_LEN);

   if (SW < 4) begin : g_bad_sw
      $error("sample width must be at least 4");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("payload buffer needs two or more entries");
   end
   if (STF_LEN < 2 || CEF_LEN < 2 || TRN_LEN < 2) begin : g_bad_len
      $error("pattern tables need two or more entries");
   end
   if (RW < 1 || GW < 1 || BW < 1) begin : g_bad_cnt
      $error("counter widths must be positive");
   end

   fld_e          fld;
   logic [IW-1:0] idx;
   logic [AW-1:0] addr;
   logic          running;
   logic [SW-1:0] stf_i, stf_q, cef_i, cef_q, trn_i, trn_q, pay_i, pay_q;

   frame_seq_ctrl #(
      .STF_LEN (STF_LEN),
      .CEF_LEN (CEF_LEN),
      .TRN_LEN (TRN_LEN),
      .AW      (AW),
      .IW      (IW),
      .RW      (RW),
      .GW      (GW),
      .BW      (BW)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .stop         (stop),
      .cfg_stf_rep  (cfg_stf_rep),
      .cfg_cef_rep  (cfg_cef_rep),
      .cfg_pay_last (cfg_pay_last),
      .cfg_trn_num  (cfg_trn_num),
      .cfg_gap      (cfg_gap),
      .cfg_beam     (cfg_beam),
      .fld          (fld),
      .idx          (idx),
      .addr         (addr),
      .beam         (out_beam),
      .frame_first  (out_sof)
   );

   assign running = (fld != FLD_OFF);

   frame_pay_buf #(
      .DEPTH (DEPTH),
      .SW    (SW)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock    (running),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_i    (wr_i),
      .wr_q    (wr_q),
      .rd_addr (addr),
      .rd_i    (pay_i),
      .rd_q    (pay_q)
   );

   frame_pat_rom #(.KIND(PAT_STF), .LEN(STF_LEN), .SW(SW)) u_stf (
      .idx   (idx[STF_IW-1:0]),
      .pat_i (stf_i),
      .pat_q (stf_q)
   );

   frame_pat_rom #(.KIND(PAT_CEF), .LEN(CEF_LEN), .SW(SW)) u_cef (
      .idx   (idx[CEF_IW-1:0]),
      .pat_i (cef_i),
      .pat_q (cef_q)
   );

   frame_pat_rom #(.KIND(PAT_TRN), .LEN(TRN_LEN), .SW(SW)) u_trn (
      .idx   (idx[TRN_IW-1:0]),
      .pat_i (trn_i),
      .pat_q (trn_q)
   );

   always_comb begin
      unique case (fld)
         FLD_STF: begin out_i = stf_i; out_q = stf_q; end
         FLD_CEF: begin out_i = cef_i; out_q = cef_q; end
         FLD_PAY: begin out_i = pay_i; out_q = pay_q; end
         FLD_TRN: begin out_i = trn_i; out_q = trn_q; end
         default: begin out_i = '0;    out_q = '0;    end
      endcase
   end

   assign out_valid = running;
   assign out_field = fld;

   AST_BEAM_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (fld == FLD_TRN && idx != '0) |-> $stable(out_beam)); // R6

   AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |=> !out_sof); // R11

   AST_SOF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> (out_valid && out_field == 3'd1)); // R11

endmodule

// File: tb/sim_frame_loop_seq.sv
`timescale 1ns/1ps
module sim_frame_loop_seq;

   localparam int SW = 12, DEPTH = 32, STF_LEN = 16, CEF_LEN = 32, TRN_LEN = 8;
   localparam int RW = 4, GW = 8, BW = 4, AW = 5;
   localparam int A = 2 ** (SW - 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, stop = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [SW-1:0] wr_i = '0, wr_q = '0;
   logic [RW-1:0] cfg_stf_rep = '0, cfg_cef_rep = '0, cfg_trn_num = '0;
   logic [AW-1:0] cfg_pay_last = '0;
   logic [GW-1:0] cfg_gap = '0;
   logic [BW-1:0] cfg_beam = '0;
   logic out_valid, out_sof;
   logic [2:0] out_field;
   logic [SW-1:0] out_i, out_q;
   logic [BW-1:0] out_beam;

   always #2 clk = ~clk;

   frame_loop_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_i(wr_i), .wr_q(wr_q),
      .cfg_stf_rep(cfg_stf_rep), .cfg_cef_rep(cfg_cef_rep), .cfg_pay_last(cfg_pay_last),
      .cfg_trn_num(cfg_trn_num), .cfg_gap(cfg_gap), .cfg_beam(cfg_beam),
      .out_valid(out_valid), .out_sof(out_sof), .out_field(out_field),
      .out_i(out_i), .out_q(out_q), .out_beam(out_beam)
   );

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // reference model state
   int mem_i [DEPTH];
   int mem_q [DEPTH];
   int e_fld[$], e_i[$], e_q[$], e_beam[$], e_sof[$];
   bit m_run = 0;
   int m_pos = 0;
   int m_beam = 0;

   task automatic chk(string tag, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   function automatic int stf_i(int k); return (k % 2 == 0) ? A : -A; endfunction
   function automatic int stf_q(int k); return ((k / 2) % 2 == 0) ? A : -A; endfunction
   function automatic int cef_i(int k);
      return ((16'h0F35 >> (k % 16)) & 1) != 0 ? -A : A;
   endfunction
   function automatic int trn_i(int k); return (k < TRN_LEN / 2) ? A : -A; endfunction

   task automatic push(int f, int i, int q, int b, int s);
      e_fld.push_back(f); e_i.push_back(i); e_q.push_back(q);
      e_beam.push_back(b); e_sof.push_back(s);
   endtask

   // expected content of one pass, built from the requirement text (R3, R5, R6, R7)
   task automatic build_pass(int s, int c, int last, int t, int g, int b);
      e_fld.delete(); e_i.delete(); e_q.delete(); e_beam.delete(); e_sof.delete();
      for (int r = 0; r <= s; r++)
         for (int k = 0; k < STF_LEN; k++) push(1, stf_i(k), stf_q(k), b, (r == 0 && k == 0) ? 1 : 0);
      for (int r = 0; r <= c; r++)
         for (int k = 0; k < CEF_LEN; k++) push(2, cef_i(k), -cef_i(k), b, 0);
      for (int a = 0; a <= last; a++) push(3, mem_i[a], mem_q[a], b, 0);
      for (int r = 0; r < t; r++)
         for (int k = 0; k < TRN_LEN; k++) push(4, trn_i(k), 0, (b + 1 + r) % (2 ** BW), 0);
      for (int n = 0; n < g; n++) push(5, 0, 0, b, 0);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_pos = 0; m_beam = 0;
      end else begin
         if (wr_en && !m_run) begin
            mem_i[wr_addr] = int'($signed(wr_i));
            mem_q[wr_addr] = int'($signed(wr_q));
         end
         if (stop) m_run = 0;
         else if (start && !m_run) begin
            m_beam = int'(cfg_beam);
            build_pass(int'(cfg_stf_rep), int'(cfg_cef_rep), int'(cfg_pay_last),
                       int'(cfg_trn_num), int'(cfg_gap), int'(cfg_beam));
            m_pos = 0; m_run = 1;
         end else if (m_run) m_pos = (m_pos + 1) % e_fld.size();
      end
   end

   function automatic string data_tag(int f);
      case (f)
         3: return "R4";
         5: return "R7";
         0: return "R9";
         default: return "R5";
      endcase
   endfunction

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (m_run) begin
            chk("R2", "valid", int'(out_valid), 1);
            chk("R3", "field", int'(out_field), e_fld[m_pos]);
            chk(data_tag(e_fld[m_pos]), "I", int'($signed(out_i)), e_i[m_pos]);
            chk(data_tag(e_fld[m_pos]), "Q", int'($signed(out_q)), e_q[m_pos]);
            chk("R6", "beam", int'(out_beam), e_beam[m_pos]);
            chk("R11", "sof", int'(out_sof), e_sof[m_pos]);
         end else begin
            chk("R9", "valid", int'(out_valid), 0);
            chk("R9", "field", int'(out_field), 0);
            chk("R9", "I", int'($signed(out_i)), 0);
            chk("R11", "sof", int'(out_sof), 0);
            chk("R6", "beam", int'(out_beam), m_beam);
         end
      end
   end

   task automatic wr(int a, int i, int q);
      wr_en = 1'b1; wr_addr = AW'(a); wr_i = SW'(i); wr_q = SW'(q);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_field(int f);
      for (int n = 0; n < 3000 && int'(out_field) != f; n++) @(negedge clk);
   endtask

   task automatic cfg(int s, int c, int last, int t, int g, int b);
      cfg_stf_rep = RW'(s); cfg_cef_rep = RW'(c); cfg_pay_last = AW'(last);
      cfg_trn_num = RW'(t); cfg_gap = GW'(g); cfg_beam = BW'(b);
   endtask

   initial begin
      int glen;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "valid in reset", int'(out_valid), 0);
      chk("R1", "field in reset", int'(out_field), 0);
      chk("R1", "beam in reset", int'(out_beam), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "sof after reset", int'(out_sof), 0);
      chk("R1", "I after reset", int'(out_i), 0);

      for (int a = 1; a < DEPTH; a++) wr(a, a * 37 - 300, 200 - a * 11);
      cfg(0, 0, 7, 2, 3, 5);
      // R8: write to address 0 in the same cycle as the starting pulse
      wr_en = 1'b1; wr_addr = '0; wr_i = SW'(511); wr_q = SW'(-511); start = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; start = 1'b0;
      chk("R2", "first field", int'(out_field), 1);
      chk("R11", "first sof", int'(out_sof), 1);
      chk("R5", "first STF I", int'($signed(out_i)), A);
      wait_field(3);
      chk("R8", "write with start stored", int'($signed(out_i)), 511);
      repeat (120) @(negedge clk);

      // R8, R10, R2: activity while running must not matter
      wr(0, 5, 5);
      cfg(2, 2, 3, 1, 7, 9);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_field(2);
      wait_field(3);
      chk("R8", "write while running ignored", int'($signed(out_i)), 511);
      wait_field(5);
      glen = 0;
      for (int n = 0; n < 50 && int'(out_field) == 5; n++) begin glen++; @(negedge clk); end
      chk("R10", "gap length kept", glen, 3);
      repeat (40) @(negedge clk);

      // R9: stop, then stop and start together while halted
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      chk("R9", "stopped valid", int'(out_valid), 0);
      stop = 1'b1; start = 1'b1; @(negedge clk); stop = 1'b0; start = 1'b0;
      chk("R9", "stop beats start", int'(out_valid), 0);

      // R7: no training, no gap
      cfg(1, 1, DEPTH - 1, 0, 0, 3);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_field(3);
      for (int n = 0; n < 100 && int'(out_field) == 3; n++) @(negedge clk);
      chk("R7", "payload followed by STF", int'(out_field), 1);
      repeat (140) @(negedge clk);
      stop = 1'b1; @(negedge clk); stop = 1'b0;

      // R6: beam wraps past its top value
      cfg(0, 0, 3, 3, 2, 15);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_field(4);
      chk("R6", "first subfield beam", int'(out_beam), 0);
      repeat (160) @(negedge clk);
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      @(negedge clk);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule